// File: doc/BRIEF.md
# Successor Label Flow Checker

This block is a hardware watchdog for control-flow checking by assigned labels. Instrumented software writes a fixed-length label to the checker each time it enters a branch-free block of code, and also when it enters or leaves a procedure. Each label is made of three sublabels, a procedure identifier and a task identifier. The checker keeps the most recent block label of each task. A new block label is legal only when one of its sublabels is exactly one more than one of the stored sublabels. This arithmetic relation is how neighbouring nodes of the control-flow graph were numbered when the labels were assigned.

Beside the successor rule, the checker keeps a per-task stack of procedure identifiers that mirrors the call stack. A procedure-entry label pushes its identifier. A procedure-exit label must name the identifier on top of the stack. Every block label must name the procedure on top of the stack, which catches a jump into the wrong procedure. Four task contexts are held side by side, and the current-task input picks which one is checked and updated. A label whose task field differs from the current task is rejected, which catches a faulty scheduler.

Errors come out as one-cycle pulses by class, registered one cycle after the label. A sticky flag collects all of them until reset. Building the labels from the program graph is done offline and is not part of this block.

Top module: `flow_label_monitor`

## Requirements
- R1: `lbl_subs` carries three sublabels, with slot k in bits [k*SUB_W +: SUB_W]. The `lbl_kind` codes are: 0 block label, 1 procedure entry, 2 procedure exit, 3 no operation. A code-3 label whose task matches changes no state and raises no error.
- R2: A block label in a task that already holds a stored label raises `err_succ` when no sublabel of the new label equals any stored sublabel plus one, with the plus-one taken modulo 2^SUB_W (255 is followed by 0).
- R3: Every accepted block label replaces its task's stored label, whether it passed the successor rule or not.
- R4: The first block label after reset, or after its task's context is cleared, skips the successor rule and becomes the stored label.
- R5: A procedure-entry label pushes its procedure ID. A procedure-exit label whose ID equals the top of the stack pops it. A procedure-exit label with any other ID raises `err_proc` and leaves the stack unchanged.
- R6: A procedure-entry label on a stack already holding STK_DEPTH (8) IDs raises `err_overflow` and pushes nothing. A procedure-exit label on an empty stack raises `err_underflow`.
- R7: A block label whose procedure ID differs from the top of the stack raises `err_proc`; an empty stack reads as ID 0. The successor rule and the label store still apply to that label.
- R8: Each task has its own stored label, first-label state and stack. Only the context chosen by `cur_task` is checked or changed.
- R9: A label whose task field differs from `cur_task` raises `err_task` and nothing else. It changes no state.
- R10: `ctx_clear` empties the stack of `cur_task` and forgets its stored label. A label presented in the same cycle is ignored.
- R11: Each error output is a one-cycle pulse in the cycle after the offending label. `err_sticky` rises in the same cycle as the first pulse and stays high until reset.
- R12: While and after synchronous reset, all outputs are low, every stack is empty and no task holds a stored label.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lbl_valid | input | 1 | A label is presented this cycle |
| lbl_kind | input | 2 | Label kind code (see R1) |
| lbl_subs | input | NSUB*SUB_W | Three sublabels |
| lbl_proc | input | PROC_W | Procedure ID carried by the label |
| lbl_task | input | TASK_W | Task ID carried by the label |
| cur_task | input | TASK_W | Task currently running |
| ctx_clear | input | 1 | Clear the context of the current task |
| err_succ | output | 1 | Illegal successor pulse |
| err_proc | output | 1 | Procedure ID mismatch pulse |
| err_overflow | output | 1 | Stack overflow pulse |
| err_underflow | output | 1 | Stack underflow pulse |
| err_task | output | 1 | Task ID mismatch pulse |
| err_sticky | output | 1 | Any error since reset |

## Verification
The bench aims at the wrap of the plus-one at 255 to 0. A design that compares without wrapping flags a legal label there. It checks that an illegal label still becomes the stored label; a design that keeps the old label reports errors on every later label. The ninth nested entry and the exit on an empty stack are driven, since an off-by-one in the depth count either corrupts the stack or misses the error. Rejected task labels, same-cycle clears and no-operation codes are each followed by a label whose outcome depends on the old state, and a switch of the current task checks that contexts do not leak into one another.

// File: rtl/flow_pkg.sv
package flow_pkg;

  typedef enum logic [1:0] {
    K_BLOCK = 2'd0,
    K_ENTER = 2'd1,
    K_LEAVE = 2'd2,
    K_NOP   = 2'd3
  } lbl_kind_e;

  typedef struct packed {
    logic succ;
    logic proc;
    logic ovf;
    logic unf;
    logic tsk;
  } err_vec_t;

endpackage

// File: rtl/flow_succ_cmp.sv
module flow_succ_cmp #(
  parameter int SUB_W = 8,
  parameter int NSUB  = 3,
  localparam int LBL_W = SUB_W * NSUB
) (
  input  logic [LBL_W-1:0] cand,
  input  logic [LBL_W-1:0] prev,
  output logic             hit
);

  logic [NSUB*NSUB-1:0] pair_hit;

  for (genvar j = 0; j < NSUB; j++) begin : g_prev
    logic [SUB_W-1:0] nxt;
    assign nxt = prev[j*SUB_W +: SUB_W] + SUB_W'(1);
    for (genvar i = 0; i < NSUB; i++) begin : g_cand
      assign pair_hit[j*NSUB+i] = (cand[i*SUB_W +: SUB_W] == nxt);
    end
  end

  assign hit = |pair_hit;

endmodule

// File: rtl/flow_ctx_store.sv
module flow_ctx_store #(
  parameter int NTASK = 4,
  parameter int LBL_W = 24,
  localparam int TASK_W = $clog2(NTASK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TASK_W-1:0] sel,
  input  logic              wr_en,
  input  logic [LBL_W-1:0]  wr_label,
  input  logic              clr,
  output logic [LBL_W-1:0]  rd_label,
  output logic              rd_primed
);

  logic [LBL_W-1:0] lbl_mem [NTASK];
  logic [NTASK-1:0] primed_q;

  always_ff @(posedge clk) begin
    if (wr_en) lbl_mem[sel] <= wr_label;
  end

  always_ff @(posedge clk) begin
    if (rst)        primed_q      <= '0;
    else if (clr)   primed_q[sel] <= 1'b0;
    else if (wr_en) primed_q[sel] <= 1'b1;
  end

  assign rd_label  = lbl_mem[sel];
  assign rd_primed = primed_q[sel];

endmodule

// File: rtl/flow_proc_stack.sv
module flow_proc_stack #(
  parameter int NTASK = 4,
  parameter int DEPTH = 8,
  parameter int ID_W  = 4,
  localparam int TASK_W = $clog2(NTASK),
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = TASK_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TASK_W-1:0] sel,
  input  logic              push,
  input  logic              pop,
  input  logic              clr,
  input  logic [ID_W-1:0]   push_id,
  output logic [ID_W-1:0]   top_id,
  output logic              empty,
  output logic              full
);

  logic [ID_W-1:0]  mem [1 << ADDR_W];
  logic [CNT_W-1:0] cnt_q [NTASK];
  logic [CNT_W-1:0] cur_cnt;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] top_ptr;

  assign cur_cnt = cnt_q[sel];
  assign empty   = (cur_cnt == '0);
  assign full    = (cur_cnt == CNT_W'(DEPTH));
  assign wr_ptr  = cur_cnt[PTR_W-1:0];
  assign top_ptr = wr_ptr - PTR_W'(1);

  // one write port, asynchronous read of the top entry
  always_ff @(posedge clk) begin
    if (push && !full) mem[{sel, wr_ptr}] <= push_id;
  end

  assign top_id = empty ? '0 : mem[{sel, top_ptr}];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NTASK; t++) cnt_q[t] <= '0;
    end else if (clr) begin
      cnt_q[sel] <= '0;
    end else if (push && !full) begin
      cnt_q[sel] <= cur_cnt + CNT_W'(1);
    end else if (pop && !empty) begin
      cnt_q[sel] <= cur_cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/flow_label_monitor.sv
module flow_label_monitor
  import flow_pkg::*;
#(
  parameter int SUB_W     = 8,
  parameter int NSUB      = 3,
  parameter int PROC_W    = 4,
  parameter int NTASK     = 4,
  parameter int STK_DEPTH = 8,
  localparam int TASK_W = $clog2(NTASK),
  localparam int LBL_W  = NSUB * SUB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lbl_valid,
  input  logic [1:0]        lbl_kind,
  input  logic [LBL_W-1:0]  lbl_subs,
  input  logic [PROC_W-1:0] lbl_proc,
  input  logic [TASK_W-1:0] lbl_task,
  input  logic [TASK_W-1:0] cur_task,
  input  logic              ctx_clear,
  output logic              err_succ,
  output logic              err_proc,
  output logic              err_overflow,
  output logic              err_underflow,
  output logic              err_task,
  output logic              err_sticky
);

  lbl_kind_e         kind;
  logic              take, task_ok, act;
  logic              is_blk, is_ent, is_lv;
  logic [LBL_W-1:0]  prev_label;
  logic              prev_primed;
  logic              succ_hit;
  logic [PROC_W-1:0] top_id;
  logic              stk_empty, stk_full;
  logic              do_push, do_pop;
  err_vec_t          err_d, err_q;
  logic              sticky_q;

  assign kind    = lbl_kind_e'(lbl_kind);
  assign take    = lbl_valid && !ctx_clear;
  assign task_ok = (lbl_task == cur_task);
  assign act     = take && task_ok;
  assign is_blk  = act && (kind == K_BLOCK);
  assign is_ent  = act && (kind == K_ENTER);
  assign is_lv   = act && (kind == K_LEAVE);

  flow_ctx_store #(.NTASK(NTASK), .LBL_W(LBL_W)) u_ctx (
    .clk       (clk),
    .rst       (rst),
    .sel       (cur_task),
    .wr_en     (is_blk),
    .wr_label  (lbl_subs),
    .clr       (ctx_clear),
    .rd_label  (prev_label),
    .rd_primed (prev_primed)
  );

  flow_succ_cmp #(.SUB_W(SUB_W), .NSUB(NSUB)) u_cmp (
    .cand (lbl_subs),
    .prev (prev_label),
    .hit  (succ_hit)
  );

  assign do_push = is_ent && !stk_full;
  assign do_pop  = is_lv && !stk_empty && (lbl_proc == top_id);

  flow_proc_stack #(.NTASK(NTASK), .DEPTH(STK_DEPTH), .ID_W(PROC_W)) u_stk (
    .clk     (clk),
    .rst     (rst),
    .sel     (cur_task),
    .push    (do_push),
    .pop     (do_pop),
    .clr     (ctx_clear),
    .push_id (lbl_proc),
    .top_id  (top_id),
    .empty   (stk_empty),
    .full    (stk_full)
  );

  always_comb begin
    err_d      = '0;
    err_d.succ = is_blk && prev_primed && !succ_hit;
    err_d.proc = (is_blk && (lbl_proc != top_id)) ||
                 (is_lv && !stk_empty && (lbl_proc != top_id));
    err_d.ovf  = is_ent && stk_full;
    err_d.unf  = is_lv && stk_empty;
    err_d.tsk  = take && !task_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q    <= '0;
      sticky_q <= 1'b0;
    end else begin
      err_q    <= err_d;
      sticky_q <= sticky_q | (|err_d);
    end
  end

  assign err_succ      = err_q.succ;
  assign err_proc      = err_q.proc;
  assign err_overflow  = err_q.ovf;
  assign err_underflow = err_q.unf;
  assign err_task      = err_q.tsk;
  assign err_sticky    = sticky_q;

endmodule

// File: rtl/flow_label_monitor_chk.sv
module flow_label_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic       lbl_valid,
  input logic [1:0] lbl_kind,
  input logic       ctx_clear,
  input logic       err_succ,
  input logic       err_proc,
  input logic       err_overflow,
  input logic       err_underflow,
  input logic       err_task,
  input logic       err_sticky
);

  logic any_err;
  assign any_err = err_succ | err_proc | err_overflow | err_underflow | err_task;

  // R11: sticky flag never falls outside reset
  a_r11_sticky_holds: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);

  // R11: every pulse is reflected in the sticky flag
  a_r11_pulse_sets_sticky: assert property (@(posedge clk) disable iff (rst)
    any_err |-> err_sticky);

  // R2: successor error only follows a block label
  a_r2_succ_after_block: assert property (@(posedge clk) disable iff (rst)
    err_succ |-> $past(lbl_valid && !ctx_clear && lbl_kind == 2'd0));

  // R6: overflow only follows an entry label
  a_r6_ovf_after_entry: assert property (@(posedge clk) disable iff (rst)
    err_overflow |-> $past(lbl_valid && !ctx_clear && lbl_kind == 2'd1));

  // R6: underflow only follows an exit label
  a_r6_unf_after_exit: assert property (@(posedge clk) disable iff (rst)
    err_underflow |-> $past(lbl_valid && !ctx_clear && lbl_kind == 2'd2));

  // R9: a rejected task label raises no other class
  a_r9_task_exclusive: assert property (@(posedge clk) disable iff (rst)
    err_task |-> !(err_succ || err_proc || err_overflow || err_underflow));

  // R10: no error after a cycle without a label or with a clear
  a_r10_quiet_without_label: assert property (@(posedge clk) disable iff (rst)
    $past(!lbl_valid || ctx_clear) |-> !any_err);

endmodule

bind flow_label_monitor flow_label_monitor_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .lbl_valid     (lbl_valid),
  .lbl_kind      (lbl_kind),
  .ctx_clear     (ctx_clear),
  .err_succ      (err_succ),
  .err_proc      (err_proc),
  .err_overflow  (err_overflow),
  .err_underflow (err_underflow),
  .err_task      (err_task),
  .err_sticky    (err_sticky)
);

// File: tb/sim_flow_label_monitor.sv
`timescale 1ns/1ps
module sim_flow_label_monitor;

  localparam int W  = 8;
  localparam int NS = 3;
  localparam int PW = 4;
  localparam int NT = 4;
  localparam int D  = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          lbl_valid;
  logic [1:0]    lbl_kind;
  logic [NS*W-1:0] lbl_subs;
  logic [PW-1:0] lbl_proc;
  logic [1:0]    lbl_task;
  logic [1:0]    cur_task;
  logic          ctx_clear;
  logic          err_succ, err_proc, err_overflow, err_underflow, err_task, err_sticky;

  always #2 clk = ~clk;

  flow_label_monitor u0 (
    .clk(clk), .rst(rst), .lbl_valid(lbl_valid), .lbl_kind(lbl_kind),
    .lbl_subs(lbl_subs), .lbl_proc(lbl_proc), .lbl_task(lbl_task),
    .cur_task(cur_task), .ctx_clear(ctx_clear),
    .err_succ(err_succ), .err_proc(err_proc), .err_overflow(err_overflow),
    .err_underflow(err_underflow), .err_task(err_task), .err_sticky(err_sticky)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  logic [NS*W-1:0] m_last [NT];
  bit              m_primed [NT];
  logic [PW-1:0]   m_stk [NT][D];
  int              m_cnt [NT];
  bit              m_sticky;

  function automatic logic [NS*W-1:0] pack3(input int a, input int b, input int c);
    return {W'(c), W'(b), W'(a)};
  endfunction

  function automatic bit is_next(input logic [NS*W-1:0] cand, input logic [NS*W-1:0] prev);
    bit r = 0;
    for (int i = 0; i < NS; i++)
      for (int j = 0; j < NS; j++)
        if (cand[i*W +: W] == W'(prev[j*W +: W] + 1)) r = 1;
    return r;
  endfunction

  function automatic logic [PW-1:0] m_top(input int t);
    return (m_cnt[t] == 0) ? '0 : m_stk[t][m_cnt[t]-1];
  endfunction

  // expected vector order: {succ, proc, ovf, unf, task}
  task automatic model(input bit vld, input bit clr, input logic [1:0] k,
                       input logic [NS*W-1:0] s, input logic [PW-1:0] p,
                       input logic [1:0] t, input int cur, output logic [4:0] e);
    logic [PW-1:0] top;
    e = '0;
    if (clr) begin
      m_primed[cur] = 0;
      m_cnt[cur] = 0;
    end else if (vld) begin
      if (t != 2'(cur)) e[0] = 1'b1;
      else begin
        top = m_top(cur);
        case (k)
          2'd0: begin
            if (m_primed[cur] && !is_next(s, m_last[cur])) e[4] = 1'b1;
            if (p != top) e[3] = 1'b1;
            m_last[cur] = s;
            m_primed[cur] = 1;
          end
          2'd1: begin
            if (m_cnt[cur] == D) e[2] = 1'b1;
            else begin m_stk[cur][m_cnt[cur]] = p; m_cnt[cur]++; end
          end
          2'd2: begin
            if (m_cnt[cur] == 0) e[1] = 1'b1;
            else if (p != top) e[3] = 1'b1;
            else m_cnt[cur]--;
          end
          default: ;
        endcase
      end
    end
    if (|e) m_sticky = 1;
  endtask

  task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (succ,proc,ovf,unf,task,sticky)", tag, got, exp);
    end
  endtask

  task automatic send(input string tag, input logic [1:0] k, input logic [NS*W-1:0] s,
                      input logic [PW-1:0] p, input logic [1:0] t, input int cur,
                      input bit clr, input bit vld);
    logic [4:0] e;
    @(negedge clk);
    lbl_valid = vld; lbl_kind = k; lbl_subs = s; lbl_proc = p;
    lbl_task = t; cur_task = 2'(cur); ctx_clear = clr;
    model(vld, clr, k, s, p, t, cur, e);
    @(posedge clk); #1;
    chk(tag, {err_succ, err_proc, err_overflow, err_underflow, err_task, err_sticky},
        {e, m_sticky});
    lbl_valid = 0; ctx_clear = 0;
  endtask

  task automatic blk(input string tag, input logic [NS*W-1:0] s, input logic [PW-1:0] p, input int cur);
    send(tag, 2'd0, s, p, 2'(cur), cur, 0, 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int t = 0; t < NT; t++) begin m_primed[t] = 0; m_cnt[t] = 0; end
    m_sticky = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; lbl_valid = 0; lbl_kind = 0; lbl_subs = 0; lbl_proc = 0;
    lbl_task = 0; cur_task = 0; ctx_clear = 0;
    void'($urandom(32'h5EED));
    do_reset();

    // R12: reset state
    @(posedge clk); #1;
    chk("R12 reset", {err_succ, err_proc, err_overflow, err_underflow, err_task, err_sticky}, 6'b0);

    // R4: first label accepted unchecked
    blk("R4 first label", pack3(10, 20, 30), 0, 0);
    // R2: legal successor via slot 2 stored 30
    blk("R2 legal", pack3(31, 5, 5), 0, 0);
    // R2: illegal
    blk("R2 illegal", pack3(50, 50, 50), 0, 0);
    // R3: illegal label became stored
    blk("R3 replaced", pack3(51, 51, 51), 0, 0);
    blk("R2 prep wrap", pack3(255, 52, 52), 0, 0);
    // R2: modulo wrap 255 -> 0
    blk("R2 wrap", pack3(0, 0, 0), 0, 0);

    do_reset();
    blk("R4 after reset", pack3(100, 100, 100), 0, 0);
    // R1: no-op code ignored; next label is checked against 100
    send("R1 nop", 2'd3, pack3(7, 7, 7), 9, 0, 0, 0, 1);
    blk("R1 nop no effect", pack3(101, 9, 9), 0, 0);
    // R5: entry, block in procedure, wrong exit, right exit
    send("R5 enter", 2'd1, 0, 3, 0, 0, 0, 1);
    blk("R5 block in proc", pack3(102, 102, 102), 3, 0);
    send("R5 wrong exit", 2'd2, 0, 5, 0, 0, 0, 1);
    blk("R5 stack kept", pack3(103, 103, 103), 3, 0);
    send("R5 exit", 2'd2, 0, 3, 0, 0, 0, 1);
    // R7: wrong procedure on empty stack (top reads 0)
    blk("R7 proc mismatch", pack3(104, 104, 104), 2, 0);
    blk("R7 label stored", pack3(105, 105, 105), 0, 0);
    // R6: underflow and overflow
    send("R6 underflow", 2'd2, 0, 0, 0, 0, 0, 1);
    for (int i = 1; i <= D; i++) send("R6 fill", 2'd1, 0, 4'(i), 0, 0, 0, 1);
    send("R6 overflow", 2'd1, 0, 15, 0, 0, 0, 1);
    for (int i = D; i >= 1; i--) send("R6 drain order", 2'd2, 0, 4'(i), 0, 0, 0, 1);
    // R9: task mismatch ignored
    send("R9 task mismatch", 2'd0, pack3(200, 200, 200), 0, 2'd1, 0, 0, 1);
    blk("R9 state kept", pack3(106, 106, 106), 0, 0);
    // R8: separate contexts
    send("R8 enter task0", 2'd1, 0, 6, 0, 0, 0, 1);
    blk("R8 task1 fresh", pack3(1, 1, 1), 0, 1);
    blk("R8 task0 intact", pack3(107, 107, 107), 6, 0);
    blk("R8 task1 checked", pack3(9, 9, 9), 0, 1);
    // R10: clear with label in same cycle
    send("R10 clear", 2'd0, pack3(77, 77, 77), 1, 2'd0, 0, 1, 1);
    blk("R10 after clear", pack3(40, 40, 40), 0, 0);
    blk("R11 pulse falls", pack3(41, 41, 41), 0, 0);

    // constrained random
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      int cur = (($urandom % 8) == 0) ? int'($urandom % NT) : int'(cur_task);
      int r = $urandom % 16;
      logic [NS*W-1:0] s = {W'($urandom), W'($urandom), W'($urandom)};
      logic [PW-1:0] p = PW'($urandom % 4);
      logic [1:0] t = (($urandom % 20) == 0) ? 2'($urandom) : 2'(cur);
      if (r < 10) begin
        if (($urandom % 4) != 0) begin
          int slot = $urandom % NS;
          int src  = $urandom % NS;
          s[slot*W +: W] = W'(m_last[cur][src*W +: W] + 1);
        end
        if (($urandom % 5) != 0) p = m_top(cur);
        send("R2 random block", 2'd0, s, p, t, cur, 0, 1);
      end else if (r < 12) send("R6 random enter", 2'd1, s, p, t, cur, 0, 1);
      else if (r < 14) begin
        if (($urandom % 3) != 0) p = m_top(cur);
        send("R5 random exit", 2'd2, s, p, t, cur, 0, 1);
      end else if (r == 14) send("R1 random nop", 2'd3, s, p, t, cur, 0, 1);
      else send("R10 random clear", 2'd0, s, p, t, cur, 1, ($urandom % 2) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule